// File: doc/BRIEF.md
# Dual-Channel Power-Good Qualifier

The block watches two power rails through their digitised monitor voltages and decides, for each rail, when the supply can be called good. A rail qualifies only after its voltage has stayed inside a programmable critical window for an unbroken, selectable number of timebase ticks. A rail is disqualified in the same cycle that its voltage leaves the window. Each rail drives one power-good pin. An external polarity input selects whether the pin is active-high or active-low, and the pin follows that input at once.

A small register port gives access to two registers. The delay register holds a two-bit delay code per channel. The status register reports the qualified state of each rail, where 1 always means good, and also reports the level of the polarity input. The voltage samples and the window limits are plain digital inputs. The tick input is a periodic single-cycle strobe. With a 1 kHz strobe and the default base of 50 ticks, the four delay codes give 50, 100, 200 and 400 ms.

Top module: `pgq_top`

## Requirements
- R1: A channel is in its window when uv_lim <= mon_v <= ov_lim, compared as unsigned numbers; both limits are inclusive.
- R2: The qualification delay in ticks is BASE_TICKS shifted left by the channel's delay code: code 0 gives 50, code 1 gives 100, code 2 gives 200 and code 3 gives 400 ticks with the default base.
- R3: Power-good for a channel becomes 1 in the cycle after the tick that brings its in-window tick count to the selected delay, and never before that tick.
- R4: Power-good falls to 0 in the same cycle that the voltage leaves the window, with no delay.
- R5: Only ticks seen while the channel is continuously in its window count; leaving the window restarts the count from zero, and ticks outside the window are not counted.
- R6: The delay register sits at address 0x38. Bits [1:0] hold channel 0's code and bits [3:2] hold channel 1's code. These bits can be read and written, and bits [7:4] always read 0.
- R7: The status register sits at address 0x34. Bit 0 is channel 0 good and bit 1 is channel 1 good, with 1 meaning good at either polarity. Bit 5 shows the polarity input, and all other bits read 0.
- R8: When pol_in is 1, pg_pin[i] equals channel i's good state. When pol_in is 0, pg_pin[i] is its inverse. The pin follows pol_in combinationally.
- R9: Writes to the status register have no effect, and reads of any address other than 0x34 or 0x38 return 0.
- R10: A change to a channel's delay code during a count takes effect from the next tick. If the count already meets or exceeds the new delay, that next tick sets power-good.
- R11: A synchronous active-high reset clears all counts, all good states and the delay register. The status register then reads 0x00 while pol_in is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle timebase strobe |
| pol_in | input | 1 | Output polarity select, 1 = active-high |
| mon_v | input | NCH*VW | Monitor voltage per channel, channel 0 in the low bits |
| uv_lim | input | NCH*VW | Undervoltage critical limit per channel |
| ov_lim | input | NCH*VW | Overvoltage critical limit per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| pg_pin | output | NCH | Power-good pins after polarity |

## Verification
The rails are driven with a steady in-window voltage and a count that stops one tick short of the delay and then one tick past it. This separates an off-by-one delay from a correct one for every delay code. Voltages exactly at each limit and one step beyond it distinguish inclusive comparisons from strict ones. An excursion in the middle of a count, with ticks given while the rail is out of range, tells a restarting counter apart from one that pauses or keeps running. Toggling the polarity while both rails are good, changing a delay code during a count, and writing to the status register show that the pins, the status bits and the counting each respond only to their own inputs.

// File: rtl/pgq_pkg.sv
package pgq_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;
    localparam int CODE_W = 2;

    localparam logic [REG_AW-1:0] ADDR_STATUS = 8'h34;
    localparam logic [REG_AW-1:0] ADDR_DELAY  = 8'h38;

    localparam int STAT_POL_BIT = 5;

    typedef enum logic [CODE_W-1:0] {
        DLY_X1 = 2'd0,
        DLY_X2 = 2'd1,
        DLY_X4 = 2'd2,
        DLY_X8 = 2'd3
    } dly_code_e;

    typedef struct packed {
        logic below;
        logic above;
    } win_flags_t;

    function automatic int unsigned dly_ticks(input dly_code_e code,
                                              input int unsigned base);
        return base << code;
    endfunction

    function automatic logic [REG_DW-1:0] status_used_mask(input int nch);
        logic [REG_DW-1:0] m;
        m = '0;
        for (int i = 0; i < nch; i++) m[i] = 1'b1;
        m[STAT_POL_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pgq_window.sv
module pgq_window #(
    parameter int VW = 10
) (
    input  logic [VW-1:0] mon,
    input  logic [VW-1:0] uv,
    input  logic [VW-1:0] ov,
    output logic          in_win
);
    import pgq_pkg::*;

    win_flags_t flags;

    always_comb begin
        flags.below = (mon < uv);
        flags.above = (mon > ov);
        in_win      = !(flags.below || flags.above);
    end

endmodule

// File: rtl/pgq_timer.sv
module pgq_timer #(
    parameter int BASE_TICKS = 50
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    in_win,
    input  pgq_pkg::dly_code_e      code,
    output logic                    good
);
    import pgq_pkg::*;

    localparam int CW = $clog2(BASE_TICKS * 8 + 1);

    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_nxt;
    logic [CW:0]   limit;
    logic          good_q;
    logic          reach;

    always_comb begin
        limit   = (CW+1)'(dly_ticks(code, BASE_TICKS));
        cnt_nxt = {1'b0, cnt} + 1'b1;
        reach   = (cnt_nxt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            good_q <= 1'b0;
        end else if (!in_win) begin
            cnt    <= '0;
            good_q <= 1'b0;
        end else if (!good_q && tick) begin
            if (reach) begin
                good_q <= 1'b1;
                cnt    <= '0;
            end else begin
                cnt    <= cnt_nxt[CW-1:0];
            end
        end
    end

    // drop without delay when the window is left
    assign good = good_q && in_win;

endmodule

// File: rtl/pgq_regs.sv
module pgq_regs #(
    parameter int NCH = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   reg_wr,
    input  logic [pgq_pkg::REG_AW-1:0]             reg_addr,
    input  logic [pgq_pkg::REG_DW-1:0]             reg_wdata,
    input  logic [NCH-1:0]                         good,
    input  logic                                   pol_in,
    output logic [pgq_pkg::REG_DW-1:0]             reg_rdata,
    output logic [NCH*pgq_pkg::CODE_W-1:0]         codes
);
    import pgq_pkg::*;

    localparam int DW = NCH * CODE_W;

    logic [DW-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else if (reg_wr && (reg_addr == ADDR_DELAY)) begin
            dly_q <= reg_wdata[DW-1:0];
        end
    end

    assign codes = dly_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_STATUS: begin
                reg_rdata[NCH-1:0]    = good;
                reg_rdata[STAT_POL_BIT] = pol_in;
            end
            ADDR_DELAY: begin
                reg_rdata[DW-1:0] = dly_q;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pgq_top.sv
module pgq_top #(
    parameter int NCH        = 2,
    parameter int VW         = 10,
    parameter int BASE_TICKS = 50
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic                        pol_in,
    input  logic [NCH*VW-1:0]           mon_v,
    input  logic [NCH*VW-1:0]           uv_lim,
    input  logic [NCH*VW-1:0]           ov_lim,
    input  logic                        reg_wr,
    input  logic [7:0]                  reg_addr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    output logic [NCH-1:0]              pg_pin
);
    import pgq_pkg::*;

    logic [NCH-1:0]        in_win;
    logic [NCH-1:0]        pg_good;
    logic [NCH*CODE_W-1:0] codes;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pgq_window #(.VW(VW)) u_win (
            .mon    (mon_v [g*VW +: VW]),
            .uv     (uv_lim[g*VW +: VW]),
            .ov     (ov_lim[g*VW +: VW]),
            .in_win (in_win[g])
        );

        pgq_timer #(.BASE_TICKS(BASE_TICKS)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .in_win (in_win[g]),
            .code   (dly_code_e'(codes[g*CODE_W +: CODE_W])),
            .good   (pg_good[g])
        );

        assign pg_pin[g] = pol_in ? pg_good[g] : !pg_good[g];
    end

    pgq_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .good      (pg_good),
        .pol_in    (pol_in),
        .reg_rdata (reg_rdata),
        .codes     (codes)
    );

endmodule

// File: rtl/pgq_chk.sv
module pgq_chk #(
    parameter int NCH = 2,
    parameter int VW  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              pol_in,
    input logic [NCH*VW-1:0] mon_v,
    input logic [NCH*VW-1:0] uv_lim,
    input logic [NCH*VW-1:0] ov_lim,
    input logic [7:0]        reg_addr,
    input logic [7:0]        reg_rdata,
    input logic [NCH-1:0]    pg_pin,
    input logic [NCH-1:0]    pg_good
);
    import pgq_pkg::*;

    localparam logic [7:0] USED = status_used_mask(NCH);

    for (genvar g = 0; g < NCH; g++) begin : g_c
        logic win_c;
        assign win_c = (mon_v[g*VW +: VW] >= uv_lim[g*VW +: VW]) &&
                       (mon_v[g*VW +: VW] <= ov_lim[g*VW +: VW]);

        // R4: never good while outside the window
        a_r4_low_outside: assert property (@(posedge clk) disable iff (rst)
            !win_c |-> !pg_good[g]);

        // R3: a rise only follows an in-window tick
        a_r3_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
            $rose(pg_good[g]) |-> ($past(tick) && $past(win_c)));

        // R8: pin agrees with status bits through the polarity bit
        a_r8_pin_vs_status: assert property (@(posedge clk) disable iff (rst)
            (reg_addr == ADDR_STATUS) |->
            (pg_pin[g] == (reg_rdata[STAT_POL_BIT] ? reg_rdata[g] : !reg_rdata[g])));
    end

    a_r6_delay_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_DELAY) |-> (reg_rdata[7:2*NCH] == '0));

    a_r7_status_reserved: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_STATUS) |-> ((reg_rdata & ~USED) == 8'h00));

    a_r7_status_pol: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_STATUS) |-> (reg_rdata[STAT_POL_BIT] == pol_in));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr != ADDR_STATUS) && (reg_addr != ADDR_DELAY)) |-> (reg_rdata == 8'h00));

endmodule

bind pgq_top pgq_chk #(.NCH(NCH), .VW(VW)) u_pgq_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pol_in    (pol_in),
    .mon_v     (mon_v),
    .uv_lim    (uv_lim),
    .ov_lim    (ov_lim),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pg_pin    (pg_pin),
    .pg_good   (pg_good)
);

// File: tb/test_pgq_top.sv
`timescale 1ns/1ps
module test_pgq_top;
    localparam int NCH = 2;
    localparam int VW  = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              pol_in = 1'b0;
    logic [NCH*VW-1:0] mon_v = '0;
    logic [NCH*VW-1:0] uv_lim = '0;
    logic [NCH*VW-1:0] ov_lim = '0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_addr = 8'h00;
    logic [7:0]        reg_wdata = 8'h00;
    logic [7:0]        reg_rdata;
    logic [NCH-1:0]    pg_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        int         sel;   // 0: reg_rdata, 1: pg_pin
        logic [7:0] exp;
    } item_t;

    item_t q[$];

    pgq_top #(.NCH(NCH), .VW(VW)) i_pgq_top (
        .clk(clk), .rst(rst), .tick(tick), .pol_in(pol_in),
        .mon_v(mon_v), .uv_lim(uv_lim), .ov_lim(ov_lim),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pg_pin(pg_pin)
    );

    always #5 clk = ~clk;

    // monitor: pops expectations and compares away from the rising edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = q.pop_front();
            got = (it.sel == 0) ? reg_rdata : {6'b0, pg_pin};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        q.push_back('{tag, 0, e});
        @(negedge clk); #1;
    endtask

    task automatic exp_pin(input logic [1:0] e, input string tag);
        @(posedge clk); #1;
        q.push_back('{tag, 1, {6'b0, e}});
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1 tick = 1'b1;
            @(posedge clk); #1 tick = 1'b0;
        end
    endtask

    task automatic set_v(input int ch, input int v);
        @(posedge clk); #1;
        mon_v[ch*VW +: VW] = VW'(v);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            uv_lim[c*VW +: VW] = 10'd100;
            ov_lim[c*VW +: VW] = 10'd900;
            mon_v [c*VW +: VW] = 10'd50;
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R11 / R7 / R6 / R8 reset state
        exp_rd(8'h34, 8'h00, "R11 status after reset");
        exp_rd(8'h38, 8'h00, "R11 delay after reset");
        exp_pin(2'b11, "R8 pins idle active-low");

        // R2 / R3 code 0 on channel 0
        set_v(0, 500);
        tick_n(49);
        exp_rd(8'h34, 8'h00, "R3 not good one tick early");
        tick_n(1);
        exp_rd(8'h34, 8'h01, "R2 good after 50 ticks");
        exp_pin(2'b10, "R8 ch0 pin low when good");

        // R1 boundaries
        set_v(0, 100);
        exp_rd(8'h34, 8'h01, "R1 v equal uv is in window");
        set_v(0, 99);
        exp_rd(8'h34, 8'h00, "R4 drop below uv at once");
        exp_pin(2'b11, "R4 pin released at once");
        set_v(0, 900);
        tick_n(50);
        exp_rd(8'h34, 8'h01, "R1 v equal ov is in window");
        set_v(0, 901);
        exp_rd(8'h34, 8'h00, "R1 v above ov is out");

        // R5 restart on excursion
        set_v(0, 500);
        tick_n(30);
        set_v(0, 950);
        tick_n(3);
        set_v(0, 500);
        tick_n(30);
        exp_rd(8'h34, 8'h00, "R5 count restarted after excursion");
        tick_n(20);
        exp_rd(8'h34, 8'h01, "R5 good after 50 fresh ticks");

        // R6 delay register, codes 2 and 3
        wr(8'h38, 8'hFE);
        exp_rd(8'h38, 8'h0E, "R6 delay readback masks upper bits");
        set_v(0, 50);
        set_v(1, 50);
        set_v(0, 500);
        #0 mon_v[VW +: VW] = 10'd500;
        tick_n(199);
        exp_rd(8'h34, 8'h00, "R2 code2 not good at 199");
        tick_n(1);
        exp_rd(8'h34, 8'h01, "R2 code2 good at 200");
        tick_n(199);
        exp_rd(8'h34, 8'h01, "R2 code3 not good at 399");
        tick_n(1);
        exp_rd(8'h34, 8'h03, "R2 code3 good at 400");

        // R7 / R8 polarity
        @(posedge clk); #1 pol_in = 1'b1;
        exp_rd(8'h34, 8'h23, "R7 status shows pol bit5");
        exp_pin(2'b11, "R8 active-high pins");
        @(posedge clk); #1 pol_in = 1'b0;
        exp_rd(8'h34, 8'h03, "R7 status good bits unchanged by pol");
        exp_pin(2'b00, "R8 active-low pins");

        // R9 read-only status and unmapped addresses
        wr(8'h34, 8'hFF);
        exp_rd(8'h34, 8'h03, "R9 status write ignored");
        exp_rd(8'h38, 8'h0E, "R9 delay untouched by status write");
        exp_rd(8'h00, 8'h00, "R9 unmapped addr reads zero");
        exp_rd(8'h35, 8'h00, "R9 addr 0x35 reads zero");

        // R10 code change during a count
        wr(8'h38, 8'h0F);
        set_v(0, 50);
        set_v(1, 50);
        set_v(0, 500);
        #0 mon_v[VW +: VW] = 10'd500;
        tick_n(120);
        exp_rd(8'h34, 8'h00, "R10 counting under code3");
        wr(8'h38, 8'h0C);
        exp_rd(8'h34, 8'h00, "R10 no effect before next tick");
        tick_n(1);
        exp_rd(8'h34, 8'h01, "R10 new code applied on next tick");

        // R11 reset mid operation
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        exp_rd(8'h38, 8'h00, "R11 delay cleared by reset");
        exp_rd(8'h34, 8'h00, "R11 good cleared by reset");
        tick_n(49);
        exp_rd(8'h34, 8'h00, "R11 count restarted from zero");
        tick_n(1);
        exp_rd(8'h34, 8'h03, "R11 both good with code0 after reset");

        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule